// File: doc/BRIEF.md
# Indexed Display-Mode Register Block

This block holds the mode registers of a linear-framebuffer display extension. The registers are 16 bits wide and are reached through a two-location window. Location 0 holds a register selector. Location 1 reads or writes the register that the selector points at. The file stores the horizontal and vertical resolution, the colour depth, a control word, a bank number, the virtual canvas size and the two panning offsets. It also holds an identification word and a read-only word that reports the framebuffer capacity.

A request to turn the mode on (control bit 0 going from 0 to 1) is checked against the dimension limits and the framebuffer capacity. The active width, height and line stride are then published to the scan-out logic. The same request resets the virtual geometry. A capability bit in the control word makes reads of the resolution and depth registers report the active mode instead of the stored values.

Register numbers used throughout: 0 identification, 1 horizontal resolution (XRES), 2 vertical resolution (YRES), 3 colour depth, 4 control, 5 bank, 6 virtual width, 7 virtual height, 8 horizontal offset, 9 vertical offset, 10 capacity.

Top module: `dispmode_regs`

## Requirements
- R1: A write with `addr_sel`=0 loads the full 16-bit selector. A read with `addr_sel`=0 returns the selector. Read data appears on `rdata` with `rvalid` high on the cycle after `rd_en`. `rvalid` is low in every other cycle, and a read sees the state from before a write in the same cycle.
- R2: A read through location 1 with a selector of 11 or more returns 0. A write there changes no register.
- R3: The identification register (selector 0) resets to 0xB0C5. A write to it takes effect only for values 0xB0C0 through 0xB0C5 inclusive; any other value leaves it unchanged.
- R4: Registers 1, 2, 3, 5, 6, 7, 8 and 9 store any 16-bit value written and return it on read while the capability bit is clear.
- R5: When a control write sets bit 0 while the stored bit 0 is 0, the fit test is applied. The test passes when XRES ≤ MAX_DIM, YRES ≤ MAX_DIM and XRES·4·YRES ≤ FB_BYTES, with the product computed at full width. On a pass, `act_width`=XRES, `act_height`=YRES and `act_stride`=4·XRES from the next cycle.
- R6: If the fit test fails, the active outputs keep their previous values. The active outputs change only through a passing 0→1 control write.
- R7: On every 0→1 control transition, virtual width becomes XRES, virtual height becomes YRES and both offsets become 0, whether or not the fit test passed. A control write with bit 0 already set leaves them alone.
- R8: While control bit 1 (capability) is set, a read of register 1 returns `act_width`, a read of register 2 returns `act_height` and a read of register 3 returns 32. All other registers return their stored value.
- R9: Register 10 reads FB_BYTES/65536 and ignores writes.
- R10: After reset the selector is 0, every register other than the identification and capacity registers reads 0, `act_width`=INIT_W, `act_height`=INIT_H and `act_stride`=4·INIT_W.
- R11: Control bits 5, 6 and 7 are stored and read back but trigger no action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_sel | input | 1 | 0 = selector location, 1 = data location |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid with `rvalid` |
| rvalid | output | 1 | High the cycle after `rd_en` |
| act_width | output | 16 | Active width in pixels |
| act_height | output | 16 | Active height in lines |
| act_stride | output | 18 | Active line stride in bytes |

## Verification
The block has two latencies. Register and selector writes, including the fit test and the virtual-geometry reset, take effect at the clock edge that samples the strobe. Their results, including the active outputs, are therefore observable from that edge on. Read data is registered, so `rdata` and `rvalid` are due exactly one edge after `rd_en`. The bench drives each strobe for a single cycle from the falling edge. It samples the active outputs and read data at the falling edge that follows the capturing rising edge, never earlier.

// File: rtl/dm_pkg.sv
package dm_pkg;
    localparam int REG_W    = 16;
    localparam int STRIDE_W = REG_W + 2;
    localparam int NUM_REGS = 11;

    localparam logic [REG_W-1:0] IX_ID   = 16'd0;
    localparam logic [REG_W-1:0] IX_XRES = 16'd1;
    localparam logic [REG_W-1:0] IX_YRES = 16'd2;
    localparam logic [REG_W-1:0] IX_BPP  = 16'd3;
    localparam logic [REG_W-1:0] IX_CTRL = 16'd4;
    localparam logic [REG_W-1:0] IX_BANK = 16'd5;
    localparam logic [REG_W-1:0] IX_VW   = 16'd6;
    localparam logic [REG_W-1:0] IX_VH   = 16'd7;
    localparam logic [REG_W-1:0] IX_XOFF = 16'd8;
    localparam logic [REG_W-1:0] IX_YOFF = 16'd9;
    localparam logic [REG_W-1:0] IX_MEM  = 16'd10;

    localparam logic [REG_W-1:0] ID_LO    = 16'hB0C0;
    localparam logic [REG_W-1:0] ID_HI    = 16'hB0C5;
    localparam logic [REG_W-1:0] CAPS_BPP = 16'd32;

    localparam int CTRL_ON   = 0;
    localparam int CTRL_CAPS = 1;

    typedef struct packed {
        logic [REG_W-1:0]    sel;
        logic [REG_W-1:0]    id;
        logic [REG_W-1:0]    xres;
        logic [REG_W-1:0]    yres;
        logic [REG_W-1:0]    bpp;
        logic [REG_W-1:0]    ctrl;
        logic [REG_W-1:0]    bank;
        logic [REG_W-1:0]    vw;
        logic [REG_W-1:0]    vh;
        logic [REG_W-1:0]    xoff;
        logic [REG_W-1:0]    yoff;
        logic [REG_W-1:0]    act_w;
        logic [REG_W-1:0]    act_h;
        logic [STRIDE_W-1:0] stride;
        logic [REG_W-1:0]    rdata;
        logic                rvalid;
    } dm_state_t;
endpackage

// File: rtl/dm_fit_check.sv
module dm_fit_check
    import dm_pkg::*;
#(
    parameter int unsigned FB_BYTES = 2097152,
    parameter int unsigned MAX_DIM  = 4096
) (
    input  logic [REG_W-1:0] xres,
    input  logic [REG_W-1:0] yres,
    output logic             fits
);
    localparam int AREA_W  = 2 * REG_W;
    localparam int BYTES_W = AREA_W + 2;

    logic [AREA_W-1:0]  area;
    logic [BYTES_W-1:0] bytes_needed;
    logic               x_ok, y_ok, mem_ok;

    always_comb begin
        area         = AREA_W'(xres) * AREA_W'(yres);
        bytes_needed = {area, 2'b00};
        x_ok         = 32'(xres) <= MAX_DIM;
        y_ok         = 32'(yres) <= MAX_DIM;
        mem_ok       = bytes_needed <= BYTES_W'(FB_BYTES);
        fits         = x_ok && y_ok && mem_ok;
    end
endmodule

// File: rtl/dm_rd_mux.sv
module dm_rd_mux
    import dm_pkg::*;
#(
    parameter logic [REG_W-1:0] MEM_UNITS = 16'd32
) (
    input  dm_state_t        st,
    input  logic             addr_sel,
    output logic [REG_W-1:0] value
);
    logic [REG_W-1:0] file_arr [NUM_REGS];
    logic             caps;

    always_comb begin
        file_arr[0]  = st.id;
        file_arr[1]  = st.xres;
        file_arr[2]  = st.yres;
        file_arr[3]  = st.bpp;
        file_arr[4]  = st.ctrl;
        file_arr[5]  = st.bank;
        file_arr[6]  = st.vw;
        file_arr[7]  = st.vh;
        file_arr[8]  = st.xoff;
        file_arr[9]  = st.yoff;
        file_arr[10] = MEM_UNITS;
    end

    always_comb begin
        caps = st.ctrl[CTRL_CAPS];
        if (!addr_sel) begin
            value = st.sel;
        end else if (caps && st.sel == IX_XRES) begin
            value = st.act_w;
        end else if (caps && st.sel == IX_YRES) begin
            value = st.act_h;
        end else if (caps && st.sel == IX_BPP) begin
            value = CAPS_BPP;
        end else if (st.sel < REG_W'(NUM_REGS)) begin
            value = file_arr[st.sel[3:0]];
        end else begin
            value = '0;
        end
    end
endmodule

// File: rtl/dispmode_regs.sv
module dispmode_regs
    import dm_pkg::*;
#(
    parameter int unsigned FB_BYTES = 2097152,
    parameter int unsigned MAX_DIM  = 4096,
    parameter int unsigned INIT_W   = 640,
    parameter int unsigned INIT_H   = 480
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_sel,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [REG_W-1:0]    wdata,
    output logic [REG_W-1:0]    rdata,
    output logic                rvalid,
    output logic [REG_W-1:0]    act_width,
    output logic [REG_W-1:0]    act_height,
    output logic [STRIDE_W-1:0] act_stride
);
    localparam logic [REG_W-1:0] MEM_UNITS = REG_W'(FB_BYTES >> 16);

    dm_state_t        st_d, st_q;
    logic             fits;
    logic [REG_W-1:0] rd_val;
    logic             turn_on;

    dm_fit_check #(.FB_BYTES(FB_BYTES), .MAX_DIM(MAX_DIM)) u_fit (
        .xres (st_q.xres),
        .yres (st_q.yres),
        .fits (fits)
    );

    dm_rd_mux #(.MEM_UNITS(MEM_UNITS)) u_rmux (
        .st       (st_q),
        .addr_sel (addr_sel),
        .value    (rd_val)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_en;
        turn_on     = wdata[CTRL_ON] && !st_q.ctrl[CTRL_ON];
        if (rd_en) st_d.rdata = rd_val;
        if (wr_en && !addr_sel) begin
            st_d.sel = wdata;
        end else if (wr_en && addr_sel) begin
            case (st_q.sel)
                IX_ID:   if (wdata >= ID_LO && wdata <= ID_HI) st_d.id = wdata;
                IX_XRES: st_d.xres = wdata;
                IX_YRES: st_d.yres = wdata;
                IX_BPP:  st_d.bpp  = wdata;
                IX_BANK: st_d.bank = wdata;
                IX_VW:   st_d.vw   = wdata;
                IX_VH:   st_d.vh   = wdata;
                IX_XOFF: st_d.xoff = wdata;
                IX_YOFF: st_d.yoff = wdata;
                IX_CTRL: begin
                    if (turn_on) begin
                        if (fits) begin
                            st_d.act_w  = st_q.xres;
                            st_d.act_h  = st_q.yres;
                            st_d.stride = {st_q.xres, 2'b00};
                        end
                        st_d.vw   = st_q.xres;
                        st_d.vh   = st_q.yres;
                        st_d.xoff = '0;
                        st_d.yoff = '0;
                    end
                    st_d.ctrl = wdata;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.id     <= ID_HI;
            st_q.act_w  <= REG_W'(INIT_W);
            st_q.act_h  <= REG_W'(INIT_H);
            st_q.stride <= STRIDE_W'(INIT_W * 4);
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata      = st_q.rdata;
    assign rvalid     = st_q.rvalid;
    assign act_width  = st_q.act_w;
    assign act_height = st_q.act_h;
    assign act_stride = st_q.stride;
endmodule

// File: rtl/dm_checker.sv
module dm_checker
    import dm_pkg::*;
#(
    parameter int unsigned FB_BYTES = 2097152,
    parameter int unsigned MAX_DIM  = 4096
) (
    input logic                clk,
    input logic                rst_n,
    input logic                addr_sel,
    input logic                wr_en,
    input logic                rd_en,
    input logic [REG_W-1:0]    wdata,
    input logic [REG_W-1:0]    rdata,
    input logic                rvalid,
    input logic [REG_W-1:0]    act_width,
    input logic [REG_W-1:0]    act_height,
    input logic [STRIDE_W-1:0] act_stride
);
    logic [REG_W-1:0] sel_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) sel_seen <= '0;
        else if (wr_en && !addr_sel) sel_seen <= wdata;
    end

    assert_rvalid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);
    assert_rvalid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);
    assert_sel_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr_sel) |=> rdata == $past(sel_seen));
    assert_high_index_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr_sel && sel_seen >= 16'd11) |=> rdata == 16'd0);
    assert_capacity_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr_sel && sel_seen == IX_MEM) |=> rdata == REG_W'(FB_BYTES >> 16));
    assert_stride_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act_stride == {act_width, 2'b00});
    assert_width_only_on_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_width) |-> $past(wr_en && addr_sel && sel_seen == IX_CTRL && wdata[CTRL_ON]));
    assert_dims_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(act_width) <= MAX_DIM) && (32'(act_height) <= MAX_DIM));
endmodule

bind dispmode_regs dm_checker #(.FB_BYTES(FB_BYTES), .MAX_DIM(MAX_DIM)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_sel   (addr_sel),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wdata      (wdata),
    .rdata      (rdata),
    .rvalid     (rvalid),
    .act_width  (act_width),
    .act_height (act_height),
    .act_stride (act_stride)
);

// File: tb/sim_dispmode_regs.sv
`timescale 1ns/1ps
module sim_dispmode_regs;
    localparam int unsigned FB = 2097152;
    localparam int unsigned MD = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rvalid;
    logic [15:0] act_width, act_height;
    logic [17:0] act_stride;

    int vectors = 0;
    int errors  = 0;
    int ew = 640, eh = 480;

    always #4 clk = ~clk;

    dispmode_regs #(.FB_BYTES(FB), .MAX_DIM(MD)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .act_width(act_width),
        .act_height(act_height), .act_stride(act_stride)
    );

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        addr_sel = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, input string req, output logic [15:0] v);
        @(negedge clk);
        addr_sel = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
        chk(req, "rvalid after read", rvalid, 1);
    endtask

    task automatic wreg(input logic [15:0] ix, input logic [15:0] d);
        wr(1'b0, ix); wr(1'b1, d);
    endtask

    task automatic rreg(input logic [15:0] ix, input string req, output logic [15:0] v);
        wr(1'b0, ix); rd(1'b1, req, v);
    endtask

    task automatic check_active(input string req);
        chk(req, "act_width", act_width, ew);
        chk(req, "act_height", act_height, eh);
        chk(req, "act_stride", act_stride, ew * 4);
    endtask

    task automatic try_mode(input logic [15:0] x, input logic [15:0] y);
        logic [15:0] v;
        bit ok;
        string tag;
        wreg(16'd4, 16'h0000);
        wreg(16'd1, x); wreg(16'd2, y);
        wreg(16'd6, 16'h1234); wreg(16'd7, 16'h4321);
        wreg(16'd8, 16'h0007); wreg(16'd9, 16'h0009);
        wreg(16'd4, 16'h0001);
        ok = (x <= MD) && (y <= MD) && (longint'(x) * 4 * longint'(y) <= longint'(FB));
        tag = ok ? "R5" : "R6";
        if (ok) begin ew = x; eh = y; end
        check_active(tag);
        rreg(16'd6, "R7", v); chk("R7", "virtual width", v, x);
        rreg(16'd7, "R7", v); chk("R7", "virtual height", v, y);
        rreg(16'd8, "R7", v); chk("R7", "x offset", v, 0);
        rreg(16'd9, "R7", v); chk("R7", "y offset", v, 0);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] id_exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10", "rvalid idle", rvalid, 0);
        check_active("R10");
        rd(1'b0, "R1", v); chk("R10", "selector", v, 0);
        rd(1'b1, "R3", v); chk("R3", "id reset", v, 16'hB0C5);
        for (int i = 1; i < 10; i++) begin
            rreg(16'(i), "R10", v); chk("R10", $sformatf("reg %0d reset", i), v, 0);
        end
        rreg(16'd10, "R9", v); chk("R9", "capacity", v, FB >> 16);

        // R1 selector readback over a sweep, rvalid drops after the pulse
        for (int k = 0; k < 16; k++) begin
            logic [15:0] s;
            s = 16'(k * 16'h1111) ^ 16'h00A5;
            wr(1'b0, s);
            rd(1'b0, "R1", v); chk("R1", "selector readback", v, s);
            @(negedge clk);
            chk("R1", "rvalid one cycle only", rvalid, 0);
        end

        // R4 plain registers
        for (int i = 1; i < 10; i++) begin
            if (i != 4) begin
                logic [15:0] d;
                d = 16'(i * 16'h1357) ^ 16'hC3C3;
                wreg(16'(i), d);
                rreg(16'(i), "R4", v); chk("R4", $sformatf("reg %0d", i), v, d);
            end
        end

        // R2 out-of-range selectors
        for (int k = 0; k < 8; k++) begin
            logic [15:0] s;
            s = (k < 5) ? 16'(11 + k) : ((k == 5) ? 16'h0100 : ((k == 6) ? 16'h8004 : 16'hFFFF));
            wreg(s, 16'h5A5A);
            rreg(s, "R2", v); chk("R2", "high index read", v, 0);
        end
        check_active("R2");
        for (int i = 5; i < 10; i++) begin
            logic [15:0] d;
            d = 16'(i * 16'h1357) ^ 16'hC3C3;
            rreg(16'(i), "R2", v); chk("R2", "no alias write", v, d);
        end

        // R3 identification sweep
        id_exp = 16'hB0C5;
        for (int k = 16'hB0BE; k <= 16'hB0C7; k++) begin
            wreg(16'd0, 16'(k));
            if (k >= 16'hB0C0 && k <= 16'hB0C5) id_exp = 16'(k);
            rreg(16'd0, "R3", v); chk("R3", $sformatf("id after 0x%0h", k), v, id_exp);
        end
        wreg(16'd0, 16'h0000);
        rreg(16'd0, "R3", v); chk("R3", "id after zero", v, id_exp);

        // R9 capacity is read-only
        wreg(16'd10, 16'h0000);
        rreg(16'd10, "R9", v); chk("R9", "capacity after write", v, FB >> 16);

        // R5 R6 R7 mode enable sweep
        try_mode(16'd800, 16'd600);
        try_mode(16'd1024, 16'd513);
        try_mode(16'd1024, 16'd512);
        try_mode(16'd4097, 16'd1);
        try_mode(16'd1, 16'd4096);
        try_mode(16'd4096, 16'd129);
        try_mode(16'd4096, 16'd128);
        try_mode(16'd65535, 16'd65535);
        try_mode(16'd2, 16'd4097);
        try_mode(16'd640, 16'd480);

        // R7 no reset while already on
        wreg(16'd6, 16'h0AAA); wreg(16'd8, 16'h0033);
        wreg(16'd1, 16'd320); wreg(16'd2, 16'd200);
        wreg(16'd4, 16'h0001);
        rreg(16'd6, "R7", v); chk("R7", "vw kept when already on", v, 16'h0AAA);
        rreg(16'd8, "R7", v); chk("R7", "xoff kept when already on", v, 16'h0033);
        check_active("R6");

        // R11 extra control bits stored, no action
        wreg(16'd4, 16'h0000);
        wreg(16'd4, 16'h00E0);
        rreg(16'd4, "R11", v); chk("R11", "control readback", v, 16'h00E0);
        rreg(16'd6, "R11", v); chk("R11", "vw untouched", v, 16'h0AAA);
        check_active("R11");

        // R8 capability reads
        wreg(16'd3, 16'd8);
        wreg(16'd5, 16'h0042);
        wreg(16'd4, 16'h0002);
        rreg(16'd1, "R8", v); chk("R8", "caps xres", v, ew);
        rreg(16'd2, "R8", v); chk("R8", "caps yres", v, eh);
        rreg(16'd3, "R8", v); chk("R8", "caps bpp", v, 32);
        rreg(16'd5, "R8", v); chk("R8", "caps bank stored", v, 16'h0042);
        rreg(16'd0, "R8", v); chk("R8", "caps id stored", v, id_exp);
        wreg(16'd4, 16'h0000);
        rreg(16'd1, "R8", v); chk("R8", "stored xres", v, 320);
        rreg(16'd3, "R8", v); chk("R8", "stored bpp", v, 8);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule